// File: doc/BRIEF.md
# Seconds-Granular Watchdog with Selectable Expiry Action

This block is a host-refreshed watchdog that counts whole seconds. A one-second tick from elsewhere in the chip drives an 8-bit down-counter. The counter is loaded from a programmable interval of 1 to 255 seconds. If the host does not kick the watchdog before the interval runs out, the block performs one configured expiry action: an interrupt pulse, a device-reset request pulse, or a motor-halt request pulse. It also sets a sticky event flag that records that an expiry happened.

The interval is held in an internal register that comes out of reset at 255 seconds. Zero is not a legal interval, so the watchdog refuses to start while the stored interval is zero. When the reset action fires, the block puts its own state back to the power-up values: it disarms and restores the interval to 255. It keeps the event flag, however. The host can therefore tell, after the reset it requested, that the watchdog caused it. Only the external reset input clears that flag.

Top module: `wdt_sec_watchdog`

## Requirements
- R1: After the synchronous reset `rst`, the stored interval is 255, the watchdog is disarmed, all three action pulses are low and `wd_event_flag` is 0.
- R2: A rising edge of `wd_enable` while the stored interval N is non-zero arms the watchdog with the counter at N. With no kick or interval write, the Nth tick after arming is the expiry tick, and the action pulse is high during the cycle after that tick.
- R3: A rising edge of `wd_enable` while the stored interval is zero is ignored, and no expiry follows however many ticks arrive.
- R4: A `wd_kick` strobe while armed reloads the counter with the stored interval, so that expiry needs N further ticks.
- R5: A `wd_interval_wr` strobe stores `wd_interval` and, while armed, reloads the counter with the new value. Writing zero while armed disarms the watchdog.
- R6: Action select 2'b00 gives a one-cycle pulse on `wd_irq` at expiry. The code 2'b11 behaves the same way.
- R7: Action select 2'b01 gives a one-cycle pulse on `wd_reset_req`. The watchdog is then disarmed and the stored interval is back to 255. It rearms only on a new rising edge of `wd_enable`.
- R8: Action select 2'b10 gives a one-cycle pulse on `wd_halt_req` at expiry.
- R9: After an expiry with a non-reset action, the counter reloads and the watchdog keeps running, so the next expiry comes N ticks later.
- R10: Every expiry sets `wd_event_flag`. The flag stays set through the watchdog's own reset action and is cleared only by `rst`.
- R11: A kick or an interval write in the same cycle as the final tick prevents that expiry.
- R12: `wd_enable` low disarms the watchdog, and ticks then have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears everything including the event flag |
| tick_1s | input | 1 | One-cycle pulse once per second |
| wd_enable | input | 1 | Watchdog enable level; arming happens on its rising edge |
| wd_interval | input | 8 | Interval value in seconds, written by `wd_interval_wr` |
| wd_interval_wr | input | 1 | Strobe that stores `wd_interval` |
| wd_kick | input | 1 | Refresh strobe from the host |
| wd_action | input | 2 | Expiry action: 00/11 interrupt, 01 reset request, 10 motor halt |
| wd_irq | output | 1 | One-cycle interrupt pulse on expiry |
| wd_reset_req | output | 1 | One-cycle device-reset request on expiry |
| wd_halt_req | output | 1 | One-cycle motor-halt request on expiry |
| wd_event_flag | output | 1 | Sticky record of a watchdog expiry |

## Verification
If the counter holds a wrong value, the visible symptom is an expiry pulse one or more ticks early or late, or a pulse that never comes. When ticks arrive every cycle, that error shows within an interval's worth of cycles. A wrong arm state shows as pulses after a zero interval, after the enable falls or after a reset action, or as missing pulses after a proper enable edge. A wrong interval after the reset action shows only on the next armed run, as an expiry that does not land exactly 255 ticks after the enable edge. A lost event flag shows as soon as a reset action completes, because the flag must still read 1.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned WD_IW = 8;

    typedef enum logic [1:0] {
        WD_ACT_IRQ     = 2'b00,
        WD_ACT_RESET   = 2'b01,
        WD_ACT_HALT    = 2'b10,
        WD_ACT_IRQ_ALT = 2'b11
    } wd_action_e;

    typedef struct packed {
        logic irq;
        logic reset;
        logic halt;
    } wd_pulse_t;

    function automatic wd_pulse_t wd_decode(input logic [1:0] sel, input logic fire);
        wd_pulse_t p;
        p = '0;
        if (fire) begin
            unique case (wd_action_e'(sel))
                WD_ACT_RESET: p.reset = 1'b1;
                WD_ACT_HALT:  p.halt  = 1'b1;
                default:      p.irq   = 1'b1;
            endcase
        end
        return p;
    endfunction

    function automatic logic wd_is_reset(input logic [1:0] sel);
        return wd_action_e'(sel) == WD_ACT_RESET;
    endfunction

endpackage

// File: rtl/wdt_arm_ctrl.sv
module wdt_arm_ctrl #(
    parameter int unsigned IW = wdt_pkg::WD_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr,
    input  logic [IW-1:0] wdata,
    input  logic          fire,
    input  logic          fire_is_reset,
    output logic [IW-1:0] ival_q,
    output logic [IW-1:0] ival_nx,
    output logic          armed_q,
    output logic          armed_nx,
    output logic          reload
);
    localparam logic [IW-1:0] IVAL_RST = '1;

    logic en_d;
    logic arm_start;
    logic self_reset;

    assign self_reset = fire && fire_is_reset;
    assign arm_start  = en && !en_d && (ival_q != '0) && !armed_q;
    assign reload     = arm_start || wr;

    always_comb begin
        if (self_reset)   ival_nx = IVAL_RST;
        else if (wr)      ival_nx = wdata;
        else              ival_nx = ival_q;

        if (self_reset)              armed_nx = 1'b0;
        else if (!en)                armed_nx = 1'b0;
        else if (wr && wdata == '0)  armed_nx = 1'b0;
        else if (arm_start)          armed_nx = 1'b1;
        else                         armed_nx = armed_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ival_q  <= IVAL_RST;
            armed_q <= 1'b0;
            en_d    <= 1'b0;
        end else begin
            ival_q  <= ival_nx;
            armed_q <= armed_nx;
            en_d    <= en;
        end
    end

    // R3: arming only ever happens from a non-zero stored interval
    a_r3_no_arm_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_q) |-> $past(ival_q) != '0);

    // R7: reset action leaves the block disarmed at the power-up interval
    a_r7_self_reset_state: assert property (@(posedge clk) disable iff (rst)
        (fire && fire_is_reset) |=> (!armed_q && ival_q == IVAL_RST));

    // R5: a zero write always disarms
    a_r5_zero_write_disarms: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata == '0) |=> !armed_q);

    // R12: enable low means disarmed on the next cycle
    a_r12_enable_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !armed_q);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int unsigned IW = wdt_pkg::WD_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          kick,
    input  logic          wr,
    input  logic          armed_q,
    input  logic          armed_nx,
    input  logic          reload,
    input  logic [IW-1:0] ival_nx,
    output logic          fire,
    output logic [IW-1:0] cnt_q
);
    localparam logic [IW-1:0] ONE = IW'(1);

    logic          last_sec;
    logic [IW-1:0] cnt_nx;

    assign last_sec = (cnt_q == ONE);
    assign fire     = armed_q && tick && last_sec && !kick && !wr;

    always_comb begin
        if (!armed_nx)                         cnt_nx = ival_nx;
        else if (reload || kick || fire)       cnt_nx = ival_nx;
        else if (tick)                         cnt_nx = cnt_q - ONE;
        else                                   cnt_nx = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '1;
        else     cnt_q <= cnt_nx;
    end

    // R2: an armed counter never sits at zero
    a_r2_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> cnt_q != '0);

    // R9: a plain tick counts down by exactly one
    a_r9_tick_decrements: assert property (@(posedge clk) disable iff (rst)
        (armed_q && armed_nx && tick && !kick && !reload && cnt_q > ONE)
        |=> cnt_q == $past(cnt_q) - ONE);

    // R11: a same-cycle kick or write suppresses expiry
    a_r11_kick_blocks: assert property (@(posedge clk) disable iff (rst)
        (kick || wr) |-> !fire);

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic [1:0] sel,
    output wd_pulse_t  pulse_q,
    output logic       flag_q
);
    wd_pulse_t pulse_nx;

    assign pulse_nx = wd_decode(sel, fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= pulse_nx;
            if (fire) flag_q <= 1'b1;
        end
    end

    // R6: at most one action per expiry
    a_r6_one_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pulse_q.irq, pulse_q.reset, pulse_q.halt}));

    // R10: the event flag is sticky until rst
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> flag_q);

    // R10: any action pulse is accompanied by the flag
    a_r10_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (pulse_q.irq || pulse_q.reset || pulse_q.halt) |-> flag_q);

endmodule

// File: rtl/wdt_sec_watchdog.sv
module wdt_sec_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned IW = WD_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_1s,
    input  logic          wd_enable,
    input  logic [IW-1:0] wd_interval,
    input  logic          wd_interval_wr,
    input  logic          wd_kick,
    input  logic [1:0]    wd_action,
    output logic          wd_irq,
    output logic          wd_reset_req,
    output logic          wd_halt_req,
    output logic          wd_event_flag
);
    logic [IW-1:0] ival_q, ival_nx, cnt_q;
    logic          armed_q, armed_nx, reload, fire;
    wd_pulse_t     pulse_q;

    wdt_arm_ctrl #(.IW(IW)) u_arm (
        .clk           (clk),
        .rst           (rst),
        .en            (wd_enable),
        .wr            (wd_interval_wr),
        .wdata         (wd_interval),
        .fire          (fire),
        .fire_is_reset (wd_is_reset(wd_action)),
        .ival_q        (ival_q),
        .ival_nx       (ival_nx),
        .armed_q       (armed_q),
        .armed_nx      (armed_nx),
        .reload        (reload)
    );

    wdt_countdown #(.IW(IW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1s),
        .kick     (wd_kick),
        .wr       (wd_interval_wr),
        .armed_q  (armed_q),
        .armed_nx (armed_nx),
        .reload   (reload),
        .ival_nx  (ival_nx),
        .fire     (fire),
        .cnt_q    (cnt_q)
    );

    wdt_action u_act (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .sel     (wd_action),
        .pulse_q (pulse_q),
        .flag_q  (wd_event_flag)
    );

    assign wd_irq       = pulse_q.irq;
    assign wd_reset_req = pulse_q.reset;
    assign wd_halt_req  = pulse_q.halt;

    // R1: nothing fires while disarmed
    a_r1_disarmed_quiet: assert property (@(posedge clk) disable iff (rst)
        !armed_q |=> !(wd_irq || wd_reset_req || wd_halt_req));

endmodule

// File: tb/sim_wdt_sec_watchdog.sv
module sim_wdt_sec_watchdog;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, en = 1'b0, wr = 1'b0, kick = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [1:0] act = 2'b00;
    logic       irq, rreq, hreq, flag;

    int n_chk = 0, n_fail = 0;
    int n_irq = 0, n_rst = 0, n_halt = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_ival = 8'hFF, m_cnt = 8'hFF;
    logic       m_armed = 0, m_en_d = 0, m_flag = 0;
    logic       e_irq = 0, e_rst = 0, e_halt = 0;

    always #10 clk = ~clk;

    wdt_sec_watchdog u0 (
        .clk(clk), .rst(rst), .tick_1s(tick), .wd_enable(en),
        .wd_interval(wdata), .wd_interval_wr(wr), .wd_kick(kick),
        .wd_action(act), .wd_irq(irq), .wd_reset_req(rreq),
        .wd_halt_req(hreq), .wd_event_flag(flag)
    );

    function automatic logic [3:0] expect_pack();
        return {e_irq, e_rst, e_halt, m_flag};
    endfunction

    task automatic check(input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic cyc(input string tag);
        logic fire, arm_start, armed_n;
        logic [7:0] ival_n;
        fire   = !rst && m_armed && tick && m_cnt == 8'd1 && !kick && !wr;
        e_irq  = fire && (act == 2'b00 || act == 2'b11);
        e_rst  = fire && act == 2'b01;
        e_halt = fire && act == 2'b10;
        if (rst) begin
            m_ival = 8'hFF; m_cnt = 8'hFF; m_armed = 0; m_en_d = 0; m_flag = 0;
        end else begin
            arm_start = en && !m_en_d && m_ival != 0 && !m_armed;
            ival_n = e_rst ? 8'hFF : (wr ? wdata : m_ival);
            if (e_rst)                 armed_n = 0;
            else if (!en)              armed_n = 0;
            else if (wr && wdata == 0) armed_n = 0;
            else if (arm_start)        armed_n = 1;
            else                       armed_n = m_armed;
            if (!armed_n || arm_start || wr || kick || fire) m_cnt = ival_n;
            else if (tick)                                   m_cnt = m_cnt - 8'd1;
            if (fire) m_flag = 1;
            m_ival = ival_n; m_armed = armed_n; m_en_d = en;
        end
        @(posedge clk); #1;
        check(tag, {irq, rreq, hreq, flag}, expect_pack());
        n_irq += int'(irq); n_rst += int'(rreq); n_halt += int'(hreq);
        tick = 0; kick = 0; wr = 0;
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin tick = 1; cyc(tag); end
    endtask

    task automatic set_ival(input logic [7:0] v, input string tag);
        wdata = v; wr = 1; cyc(tag);
    endtask

    task automatic rearm(input string tag);
        en = 0; cyc(tag); en = 1; cyc(tag);
    endtask

    task automatic clr_counts();
        n_irq = 0; n_rst = 0; n_halt = 0;
    endtask

    initial begin
        rst = 1; cyc("R1"); cyc("R1");
        rst = 0; cyc("R1");
        check("R1 flag after reset", flag, 0);

        // R3: zero interval, enable ignored
        set_ival(8'd0, "R3"); en = 1; cyc("R3");
        clr_counts(); ticks(300, "R3");
        check("R3 no pulses", n_irq + n_rst + n_halt, 0);

        // R2/R6/R9: interval 3, interrupt action, continuous ticks
        en = 0; cyc("R12"); set_ival(8'd3, "R5"); act = 2'b00; en = 1; cyc("R2");
        clr_counts(); ticks(9, "R2");
        check("R9 irq count over 3 intervals", n_irq, 3);
        check("R10 flag set", flag, 1);

        // R4: kick after 2 ticks, then 2 more ticks must not expire
        clr_counts(); ticks(2, "R4"); kick = 1; cyc("R4"); ticks(2, "R4");
        check("R4 no early expiry", n_irq, 0);
        ticks(1, "R4");
        check("R4 expiry after reload", n_irq, 1);

        // R11: kick on the final tick
        clr_counts(); ticks(2, "R11"); tick = 1; kick = 1; cyc("R11");
        check("R11 kick blocks expiry", n_irq, 0);
        clr_counts(); ticks(2, "R11"); tick = 1; wdata = 8'd2; wr = 1; cyc("R11");
        check("R11 write blocks expiry", n_irq, 0);
        ticks(2, "R5");
        check("R5 new interval 2", n_irq, 1);

        // R8 halt, R6 alternate code
        act = 2'b10; clr_counts(); ticks(4, "R8");
        check("R8 halt count", n_halt, 2);
        act = 2'b11; clr_counts(); ticks(4, "R6");
        check("R6 code 11 gives irq", n_irq, 2);

        // R7 reset action
        act = 2'b01; clr_counts(); ticks(2, "R7");
        check("R7 reset pulse", n_rst, 1);
        clr_counts(); ticks(20, "R7");
        check("R7 disarmed after reset", n_rst, 0);
        check("R10 flag kept through own reset", flag, 1);
        rearm("R7"); clr_counts(); ticks(254, "R7");
        check("R7 no expiry before 255", n_rst, 0);
        ticks(1, "R7");
        check("R7 expiry at 255", n_rst, 1);

        // R10: external reset clears flag
        rst = 1; cyc("R10"); rst = 0; cyc("R10");
        check("R10 flag cleared by rst", flag, 0);

        // R12: enable low, ticks ignored
        set_ival(8'd1, "R12"); act = 2'b00; en = 1; cyc("R12"); en = 0; cyc("R12");
        clr_counts(); ticks(10, "R12");
        check("R12 disabled quiet", n_irq, 0);

        // R5: zero write while armed disarms
        en = 1; cyc("R5"); set_ival(8'd0, "R5"); clr_counts(); ticks(10, "R5");
        check("R5 zero write disarms", n_irq, 0);

        // random mix against the reference
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 6000; i++) begin
            tick = ($urandom % 3) == 0;
            kick = ($urandom % 23) == 0;
            wr   = ($urandom % 41) == 0;
            wdata = (($urandom % 8) == 0) ? 8'd0 : 8'(1 + $urandom % 6);
            if (($urandom % 57) == 0) en = ~en;
            if (($urandom % 31) == 0) act = 2'($urandom);
            rst = ($urandom % 997) == 0;
            cyc("R9 random");
        end
        rst = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule